// File: doc/BRIEF.md
# Dual-Channel Hiccup Fault Sequencer

This block is the digital timing core beside a pair of linear regulator control amplifiers. It decides, cycle by cycle, whether each amplifier may drive its external pass transistor. It watches a power-good flag, two active-low shutdown lines and two undervoltage comparator flags. Each comparator flag is high while its channel's output sits below 80% of nominal.

When power becomes good, or when either channel is switched on, one shared hold-off window starts. During that window both channels drive their outputs and every undervoltage flag is ignored. Once the window closes, a channel whose output stays low for a full deglitch interval drops into hiccup mode. In that mode its amplifier is pulsed on for a short window and off for a window forty times longer, which limits the heat in the pass device. The channel returns to continuous operation only if its output is seen good at the end of an on window. All durations are parameters counted in clock cycles.

Top module: `hiccup_seq`

## Requirements
- R1: While `por_ok` is low, every bit of `amp_en` and `hic` is low in the same cycle, and each channel starts again from its off state once `por_ok` returns high.
- R2: A low `shdn_n[i]` drives `amp_en[i]` and `hic[i]` low in the same cycle and leaves the other channel's outputs unchanged.
- R3: A rising `por_ok` starts a hold-off window of HOLD_TICKS cycles. During that window `amp_en` is high for every enabled channel and `uv` is ignored.
- R4: A rising edge on either `shdn_n` bit, seen after its two-flop synchronizer, restarts the hold-off window for both channels. A channel that is already running therefore does not trip on a fault that begins inside the new window.
- R5: After the hold-off window, a running channel enters hiccup mode only after its synchronized `uv` bit has been high for DEG_TICKS consecutive cycles. A pulse of DEG_TICKS-1 cycles or fewer has no effect on `hic` or `amp_en`.
- R6: In hiccup mode, `hic[i]` stays high. Hiccup mode starts with an off phase. `amp_en[i]` is then low for exactly OFF_TICKS cycles and high for exactly ON_TICKS cycles, and this repeats.
- R7: A channel leaves hiccup mode only when its synchronized `uv` bit is low in the last cycle of an on window. It then holds `amp_en[i]` high continuously with `hic[i]` low. If `uv` is low only during an off window, the channel stays in hiccup mode.
- R8: A channel whose `uv` bit is high when the hold-off window closes enters hiccup mode directly, without waiting for the deglitch interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| por_ok | input | 1 | High once the supply is above its reset threshold (synchronous to clk) |
| shdn_n | input | NCH | Active-low per-channel shutdown (asynchronous) |
| uv | input | NCH | Per-channel flag, high while the output is below 80% of nominal (asynchronous) |
| amp_en | output | NCH | Enable of each control amplifier |
| hic | output | NCH | High while the channel is in hiccup mode |

## Verification
Faults are applied in four ways: at power-up, during a run, during a hold-off window restarted by the other channel, and as random short pulses. Each pattern isolates one source of a trip. The power-up fault must trip exactly when the window closes. A fault that starts during the restarted window must wait for the window and then for the deglitch interval. Pulses one cycle shorter than the deglitch interval must never trip, and a pulse of exactly that length must trip. During recovery, the output is made good only in an off window, and then in an on window, which shows that the exit decision is made at the end of the on window alone.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_HOLD    = 3'd1,
        ST_RUN     = 3'd2,
        ST_HIC_ON  = 3'd3,
        ST_HIC_OFF = 3'd4
    } hic_state_e;

    // counter width able to hold the values 0 .. n-1
    function automatic int cnt_w(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

endmodule

// File: rtl/hs_holdoff.sv
module hs_holdoff #(
    parameter int NCH        = 2,
    parameter int HOLD_TICKS = 60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           por_ok,
    input  logic [NCH-1:0] shdn_s,
    output logic           hold_act
);

    localparam int HW = hiccup_pkg::cnt_w(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_TICKS);

    typedef struct packed {
        logic [HW-1:0]  cnt;
        logic           por;
        logic [NCH-1:0] shdn;
    } hold_t;

    hold_t r_q, r_d;
    logic  restart;

    always_comb begin
        r_d      = r_q;
        r_d.por  = por_ok;
        r_d.shdn = shdn_s;
        restart  = (por_ok && !r_q.por) || (por_ok && |(shdn_s & ~r_q.shdn));
        if (!por_ok) begin
            r_d.cnt = '0;
        end else if (restart) begin
            r_d.cnt = HOLD_LOAD;
        end else if (r_q.cnt != '0) begin
            r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign hold_act = (r_q.cnt != '0);

endmodule

// File: rtl/hs_chan.sv
module hs_chan
    import hiccup_pkg::*;
#(
    parameter int DEG_TICKS = 8,
    parameter int ON_TICKS  = 10,
    parameter int OFF_TICKS = 400,
    localparam int TW = cnt_w((ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_ok,
    input  logic          hold_act,
    input  logic          uv_s,
    output logic          en,
    output logic          in_hic,
    output logic [2:0]    st,
    output logic [TW-1:0] tmr
);

    localparam int DW = cnt_w(DEG_TICKS);
    localparam logic [TW-1:0] ON_LAST  = TW'(ON_TICKS - 1);
    localparam logic [TW-1:0] OFF_LAST = TW'(OFF_TICKS - 1);
    localparam logic [DW-1:0] DEG_LAST = DW'(DEG_TICKS - 1);

    typedef struct packed {
        hic_state_e    st;
        logic [TW-1:0] tmr;
        logic [DW-1:0] dcnt;
    } chan_t;

    chan_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_OFF: begin
                c_d.tmr  = '0;
                c_d.dcnt = '0;
                if (run_ok) c_d.st = ST_HOLD;
            end
            ST_HOLD: begin
                if (!hold_act) begin
                    c_d.st  = uv_s ? ST_HIC_OFF : ST_RUN;
                    c_d.tmr = '0;
                end
            end
            ST_RUN: begin
                if (uv_s && !hold_act) begin
                    if (c_q.dcnt == DEG_LAST) begin
                        c_d.st   = ST_HIC_OFF;
                        c_d.tmr  = '0;
                        c_d.dcnt = '0;
                    end else begin
                        c_d.dcnt = c_q.dcnt + 1'b1;
                    end
                end else begin
                    c_d.dcnt = '0;
                end
            end
            ST_HIC_OFF: begin
                if (c_q.tmr == OFF_LAST) begin
                    c_d.st  = ST_HIC_ON;
                    c_d.tmr = '0;
                end else begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            ST_HIC_ON: begin
                if (c_q.tmr == ON_LAST) begin
                    c_d.st  = uv_s ? ST_HIC_OFF : ST_RUN;
                    c_d.tmr = '0;
                end else begin
                    c_d.tmr = c_q.tmr + 1'b1;
                end
            end
            default: c_d.st = ST_OFF;
        endcase
        if (!run_ok) begin
            c_d.st   = ST_OFF;
            c_d.tmr  = '0;
            c_d.dcnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_OFF, tmr: '0, dcnt: '0};
        else        c_q <= c_d;
    end

    assign en     = (c_q.st == ST_HOLD) || (c_q.st == ST_RUN) || (c_q.st == ST_HIC_ON);
    assign in_hic = (c_q.st == ST_HIC_ON) || (c_q.st == ST_HIC_OFF);
    assign st     = c_q.st;
    assign tmr    = c_q.tmr;

endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
    parameter int NCH        = 2,
    parameter int HOLD_TICKS = 60,
    parameter int DEG_TICKS  = 8,
    parameter int ON_TICKS   = 10,
    parameter int OFF_TICKS  = 400
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           por_ok,
    input  logic [NCH-1:0] shdn_n,
    input  logic [NCH-1:0] uv,
    output logic [NCH-1:0] amp_en,
    output logic [NCH-1:0] hic
);

    localparam int TW = hiccup_pkg::cnt_w((ON_TICKS > OFF_TICKS) ? ON_TICKS : OFF_TICKS);

    logic [NCH-1:0]         shdn_s;
    logic [NCH-1:0]         uv_s;
    logic                   hold_act;
    logic [NCH-1:0]         ch_en;
    logic [NCH-1:0]         ch_hic;
    logic [NCH-1:0][2:0]    ch_st;
    logic [NCH-1:0][TW-1:0] ch_tmr;

    hs_sync #(.W(2*NCH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({uv, shdn_n}),
        .q     ({uv_s, shdn_s})
    );

    hs_holdoff #(.NCH(NCH), .HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .por_ok   (por_ok),
        .shdn_s   (shdn_s),
        .hold_act (hold_act)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hs_chan #(
            .DEG_TICKS (DEG_TICKS),
            .ON_TICKS  (ON_TICKS),
            .OFF_TICKS (OFF_TICKS)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run_ok   (por_ok & shdn_s[i]),
            .hold_act (hold_act),
            .uv_s     (uv_s[i]),
            .en       (ch_en[i]),
            .in_hic   (ch_hic[i]),
            .st       (ch_st[i]),
            .tmr      (ch_tmr[i])
        );
        // raw gating: shutdown and power-fail act without synchronizer delay
        assign amp_en[i] = ch_en[i]  & shdn_n[i] & por_ok;
        assign hic[i]    = ch_hic[i] & shdn_n[i] & por_ok;
    end

endmodule

// File: rtl/hs_chk.sv
module hs_chk
    import hiccup_pkg::*;
#(
    parameter int NCH       = 2,
    parameter int ON_TICKS  = 10,
    parameter int OFF_TICKS = 400,
    parameter int TW        = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   por_ok,
    input  logic                   hold_act,
    input  logic [NCH-1:0]         uv_s,
    input  logic [NCH-1:0][2:0]    ch_st,
    input  logic [NCH-1:0][TW-1:0] ch_tmr
);

    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !por_ok |=> ch_st[i] == ST_OFF);                                          // R1
        AST_HOLD_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[i] == ST_HOLD && hold_act) |=> ch_st[i] != ST_HIC_OFF);            // R3
        AST_RUN_DEGLITCH: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[i] == ST_RUN && !uv_s[i]) |=> ch_st[i] != ST_HIC_OFF);             // R5
        AST_OFF_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            ch_st[i] == ST_HIC_OFF |-> ch_tmr[i] < TW'(OFF_TICKS));                   // R6
        AST_ON_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            ch_st[i] == ST_HIC_ON |-> ch_tmr[i] < TW'(ON_TICKS));                     // R6
        AST_HIC_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
            ch_st[i] == ST_HIC_OFF |=> (ch_st[i] == ST_HIC_OFF || ch_st[i] == ST_HIC_ON
                                        || ch_st[i] == ST_OFF));                      // R7
    end

endmodule

bind hiccup_seq hs_chk #(
    .NCH       (NCH),
    .ON_TICKS  (ON_TICKS),
    .OFF_TICKS (OFF_TICKS),
    .TW        (TW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_ok   (por_ok),
    .hold_act (hold_act),
    .uv_s     (uv_s),
    .ch_st    (ch_st),
    .ch_tmr   (ch_tmr)
);

// File: tb/test_hiccup_seq.sv
module test_hiccup_seq;

    localparam int NCH  = 2;
    localparam int HOLD = 40;
    localparam int DEG  = 8;
    localparam int ON   = 5;
    localparam int OFF  = 200;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           por_ok;
    logic [NCH-1:0] shdn_n;
    logic [NCH-1:0] uv;
    logic [NCH-1:0] amp_en;
    logic [NCH-1:0] hic;

    int  nchk = 0;
    int  nerr = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    hiccup_seq #(
        .NCH(NCH), .HOLD_TICKS(HOLD), .DEG_TICKS(DEG), .ON_TICKS(ON), .OFF_TICKS(OFF)
    ) i_hiccup_seq (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .shdn_n(shdn_n),
        .uv(uv), .amp_en(amp_en), .hic(hic)
    );

    // a fault pulse trips the channel only if it lasts a full deglitch interval
    function automatic int glitch_trips(input int len);
        return (len >= DEG) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_en(input int ch, input logic v, input int lim);
        int n = 0;
        while (amp_en[ch] !== v && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_len(input int ch, input logic v, input int lim, output int n);
        n = 0;
        while (amp_en[ch] === v && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        rst_n = 1'b0; por_ok = 1'b0; shdn_n = 2'b11; uv = 2'b00;
        tick(3);
        chk("R1 reset amp_en", amp_en, 0);
        chk("R1 reset hic", hic, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 por low amp_en", amp_en, 0);

        // power-up with a fault on channel 0
        uv = 2'b01;
        por_ok = 1'b1;
        tick(HOLD - 2);
        chk("R3 holdoff amp_en", amp_en, 3);
        chk("R3 holdoff hic", hic, 0);
        tick(6);
        chk("R8 hic ch0 at holdoff end", hic, 1);
        chk("R8 amp_en ch0 off", amp_en, 2);

        // hiccup pulse widths
        wait_en(0, 1'b1, OFF + 10);
        run_len(0, 1'b1, ON + 20, n);
        chk("R6 on width", n, ON);
        run_len(0, 1'b0, OFF + 20, n);
        chk("R6 off width", n, OFF);
        chk("R6 hic during hiccup", hic[0], 1);

        // output good only during an off window: no exit
        run_len(0, 1'b1, ON + 20, n);
        uv[0] = 1'b0;
        tick(50);
        uv[0] = 1'b1;
        wait_en(0, 1'b1, OFF + 10);
        run_len(0, 1'b1, ON + 20, n);
        chk("R7 stays in hiccup", hic[0], 1);

        // output good through an on window: exit
        uv[0] = 1'b0;
        wait_en(0, 1'b1, OFF + 10);
        tick(ON + 5);
        chk("R7 hic cleared", hic[0], 0);
        tick(OFF);
        chk("R7 continuous enable", amp_en[0], 1);

        // random short glitches on running channels
        for (int k = 0; k < 20; k++) begin
            int ch  = $urandom % NCH;
            int len = 1 + ($urandom % (DEG - 1));
            uv[ch] = 1'b1;
            tick(len);
            uv[ch] = 1'b0;
            tick(10);
            chk("R5 short glitch ignored", hic[ch], glitch_trips(len));
        end

        // boundary: DEG-1 cycles ignored, DEG cycles trip
        uv[1] = 1'b1; tick(DEG - 1); uv[1] = 1'b0; tick(10);
        chk("R5 DEG-1 pulse", hic[1], glitch_trips(DEG - 1));
        uv[1] = 1'b1; tick(DEG); uv[1] = 1'b0; tick(10);
        chk("R5 DEG pulse", hic[1], glitch_trips(DEG));
        tick(OFF + ON + 20);
        chk("R7 recovered ch1", hic[1], 0);

        // shutdown of channel 0
        shdn_n[0] = 1'b0;
        #1;
        chk("R2 immediate off ch0", amp_en[0], 0);
        chk("R2 ch1 unaffected", amp_en[1], 1);
        tick(5);
        chk("R2 still off", amp_en, 2);

        // re-enable restarts the shared hold-off; ch1 faults inside it
        shdn_n[0] = 1'b1;
        uv[1] = 1'b1;
        tick(HOLD - 2);
        chk("R4 ch1 masked by restart", hic[1], 0);
        chk("R4 both enabled", amp_en, 3);
        tick(20);
        chk("R4 ch1 trips after window", hic[1], 1);
        chk("R4 ch0 runs", amp_en[0], 1);

        // hiccup cleared by shutdown
        shdn_n[1] = 1'b0;
        #1;
        chk("R2 hic cleared by shutdown", hic[1], 0);
        uv[1] = 1'b0;
        tick(5);
        shdn_n[1] = 1'b1;

        // power fail and restart
        tick(HOLD + 10);
        por_ok = 1'b0;
        #1;
        chk("R1 por drop amp_en", amp_en, 0);
        chk("R1 por drop hic", hic, 0);
        tick(5);
        por_ok = 1'b1;
        tick(HOLD + 10);
        chk("R1 restart amp_en", amp_en, 3);
        chk("R1 restart hic", hic, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule